// File: doc/BRIEF.md
# Framed Serial-to-Parallel Receiver with Even Parity

This block takes a one-bit serial line, sampled once on every rising clock edge, and gathers it into an 8-bit parallel word. The line rests at 0 between frames. A frame opens with a single 1, continues with eight data bits sent most significant bit first, and closes with an even-parity bit. Once a good frame has been taken in, the word is presented with a one-cycle valid strobe. If the line carries a 1 in that same cycle, the 1 opens the next frame without any idle gap.

When the parity bit does not match the data, the receiver raises a fault flag and freezes. It then ignores the line until a synchronous reset brings it back to the idle state. A small controller (idle, collecting, presenting, faulted) steers three pieces of state: a shift register with a bit counter, and a running XOR of the data bits.

Top module: `sercvt_rx`

## Requirements
- R1: A synchronous, active-high `rst` sampled at a rising edge sets `word_out` to 0, `word_valid` to 0 and `parity_fault` to 0 from the next cycle on, and returns the receiver to idle.
- R2: While idle, a sampled 0 on `ser_in` leaves `word_out` unchanged and keeps `word_valid` at 0.
- R3: A start bit (a 1 sampled while idle or while presenting) clears `word_out` to 0 in the following cycle.
- R4: The k-th data bit after the start bit (k = 0 to 7) is stored in `word_out[7-k]`, so the first data bit lands in the most significant position.
- R5: `word_valid` is 1 for exactly one cycle, the eleventh cycle counted from the start-bit cycle, and 0 in every other cycle.
- R6: The parity bit is accepted when it equals the XOR of the eight data bits (a 1 for an odd count of ones). On acceptance `word_out` holds the received byte during the valid cycle.
- R7: A 1 on `ser_in` during the valid cycle is the start bit of the next frame, and that frame's word is presented ten cycles later.
- R8: A 0 on `ser_in` during the valid cycle returns the receiver to idle, and `word_out` keeps the received byte until the next start bit.
- R9: A parity bit that differs from the XOR of the data bits sets `parity_fault` to 1 in the cycle where `word_valid` would have risen, and `word_valid` stays 0.
- R10: While `parity_fault` is 1, it stays 1, `word_out` does not change and `word_valid` stays 0, whatever the value of `ser_in`.
- R11: A reset taken while faulted clears `parity_fault`, and the next well-formed frame is then received and presented normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; the line is sampled once per edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial line, 0 when idle |
| word_out | output | 8 | Word being assembled, then the received word |
| word_valid | output | 1 | One-cycle strobe: `word_out` holds a good byte |
| parity_fault | output | 1 | Sticky parity-mismatch flag, cleared only by reset |

## Verification
Two situations are hard to reach from the ports. The first is the frame handoff, where the valid cycle of one frame is also the start cycle of the next. The bench reaches it by driving the next start bit exactly ten cycles after the previous one. The second is the frozen state. The bench reaches it by sending a byte with the parity bit inverted, and then plays a complete well-formed frame into the faulted receiver, so that any leak of the line into the stored word or into the strobe shows up. A behavioural model built on a bit queue predicts every output on every clock, and directed checks cover the boundary cycles.

// File: rtl/sercvt_rx_pkg.sv
package sercvt_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PRESENT = 2'd2,
        ST_FAULT   = 2'd3
    } rx_state_e;

    typedef struct packed {
        rx_state_e state;
    } ctrl_regs_t;

endpackage

// File: rtl/sercvt_rx_shift.sv
module sercvt_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] data_q,
    output logic              full
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
    } shift_regs_t;

    shift_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.data = '0;
            r_d.cnt  = '0;
        end else if (shift_en) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (r_q.cnt == CNT_W'(DATA_W - 1 - i)) begin
                    r_d.data[i] = bit_in;
                end
            end
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_q = r_q.data;
    assign full   = (r_q.cnt == CNT_W'(DATA_W));

    // R4: the bit counter never passes the word width
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        r_q.cnt <= CNT_W'(DATA_W));

    // R3: a clear request empties the word on the next cycle
    p_clear_word_r3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (data_q == '0));

endmodule

// File: rtl/sercvt_rx_parity.sv
module sercvt_rx_parity (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic acc_en,
    input  logic bit_in,
    output logic par_q
);
    logic acc_q, acc_d;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = 1'b0;
        end else if (acc_en) begin
            acc_d = acc_q ^ bit_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign par_q = acc_q;

    // R6: a new frame starts with an even (zero) running parity
    p_parity_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> !par_q);

endmodule

// File: rtl/sercvt_rx_ctrl.sv
module sercvt_rx_ctrl
    import sercvt_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic full,
    input  logic par_q,
    output logic clr,
    output logic shift_en,
    output logic valid,
    output logic fault
);
    ctrl_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        clr      = 1'b0;
        shift_en = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (ser_in) begin
                    clr         = 1'b1;
                    r_d.state   = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (!full) begin
                    shift_en = 1'b1;
                end else if (ser_in == par_q) begin
                    r_d.state = ST_PRESENT;
                end else begin
                    r_d.state = ST_FAULT;
                end
            end
            ST_PRESENT: begin
                if (ser_in) begin
                    clr       = 1'b1;
                    r_d.state = ST_COLLECT;
                end else begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_FAULT: begin
                r_d.state = ST_FAULT;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign valid = (r_q.state == ST_PRESENT);
    assign fault = (r_q.state == ST_FAULT);

    // R5: the valid strobe never lasts two cycles
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R10: the fault flag holds until reset
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

endmodule

// File: rtl/sercvt_rx.sv
module sercvt_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    output logic [DATA_W-1:0] word_out,
    output logic              word_valid,
    output logic              parity_fault
);
    logic clr, shift_en, full, par_q;

    sercvt_rx_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .full     (full),
        .par_q    (par_q),
        .clr      (clr),
        .shift_en (shift_en),
        .valid    (word_valid),
        .fault    (parity_fault)
    );

    sercvt_rx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .shift_en (shift_en),
        .bit_in   (ser_in),
        .data_q   (word_out),
        .full     (full)
    );

    sercvt_rx_parity u_parity (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .acc_en (shift_en),
        .bit_in (ser_in),
        .par_q  (par_q)
    );

    // R1: reset leaves every output at zero on the following cycle
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (word_out == '0 && !word_valid && !parity_fault));

    // R9: the strobe and the fault flag are never high together
    p_no_valid_in_fault_r9: assert property (@(posedge clk) disable iff (rst)
        parity_fault |-> !word_valid);

    // R10: the stored word is frozen while faulted
    p_fault_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        parity_fault |=> $stable(word_out));

endmodule

// File: tb/sercvt_rx_test.sv
module sercvt_rx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic [7:0] word_out;
    logic       word_valid;
    logic       parity_fault;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sercvt_rx uut (
        .clk          (clk),
        .rst          (rst),
        .ser_in       (ser_in),
        .word_out     (word_out),
        .word_valid   (word_valid),
        .parity_fault (parity_fault)
    );

    // behavioural reference: 0 idle, 1 collecting, 2 presenting, 3 locked
    int       m_mode = 0;
    bit [7:0] m_word = 0;
    bit       m_q[$];
    bit       m_live = 0;

    always @(posedge clk) begin
        bit p;
        m_live = 1;
        if (rst) begin
            m_mode = 0; m_word = 0; m_q.delete();
        end else begin
            case (m_mode)
                0: if (ser_in) begin m_mode = 1; m_word = 0; m_q.delete(); end
                1: begin
                    if (m_q.size() < 8) begin
                        m_q.push_back(ser_in);
                        m_word[8 - m_q.size()] = ser_in;
                    end else begin
                        p = 0;
                        foreach (m_q[i]) p ^= m_q[i];
                        m_mode = (ser_in == p) ? 2 : 3;
                    end
                end
                2: if (ser_in) begin m_mode = 1; m_word = 0; m_q.delete(); end
                   else m_mode = 0;
                default: ;
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (m_live && !done) begin
            check("R4 word_out vs model", word_out, m_word);
            check("R5 word_valid vs model", word_valid, m_mode == 2);
            check("R9 parity_fault vs model", parity_fault, m_mode == 3);
        end
    end

    task automatic tick(input bit b);
        ser_in = b;
        @(negedge clk);
    endtask

    // start bit + 8 data bits; the parity bit is left to the caller
    task automatic send_body(input bit [7:0] v);
        tick(1'b1);
        for (int i = 7; i >= 0; i--) tick(v[i]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 reset word", word_out, 0);
        check("R1 reset valid", word_valid, 0);
        check("R1 reset fault", parity_fault, 0);

        repeat (5) tick(1'b0);
        check("R2 idle word", word_out, 0);
        check("R2 idle valid", word_valid, 0);

        // good frame, then idle
        tick(1'b1);
        check("R3 start clears", word_out, 0);
        for (int i = 7; i >= 0; i--) tick(8'hA5 >> i);
        check("R5 no early valid", word_valid, 0);
        tick(^8'hA5);
        check("R5 valid in cycle 11", word_valid, 1);
        check("R6 byte A5", word_out, 8'hA5);
        tick(1'b0);
        check("R5 valid one cycle", word_valid, 0);
        check("R8 word held", word_out, 8'hA5);
        repeat (3) tick(1'b0);
        check("R8 word held idle", word_out, 8'hA5);
        check("R2 idle keeps word", word_valid, 0);

        // back-to-back frames
        send_body(8'h3C); tick(^8'h3C);
        check("R6 byte 3C", word_out, 8'h3C);
        tick(1'b1);
        check("R7 handoff clears", word_out, 0);
        check("R7 handoff valid low", word_valid, 0);
        for (int i = 7; i >= 0; i--) tick(8'h81 >> i);
        tick(^8'h81);
        check("R7 second valid", word_valid, 1);
        check("R7 second byte", word_out, 8'h81);
        send_body(8'hFF); tick(1'b0);
        check("R6 byte FF even", word_out, 8'hFF);
        check("R6 FF valid", word_valid, 1);
        send_body(8'h07); tick(1'b1);
        check("R6 byte 07 odd", word_out, 8'h07);
        tick(1'b0); tick(1'b0);

        // corrupted parity
        send_body(8'h5A); tick(1'b1);
        check("R9 fault raised", parity_fault, 1);
        check("R9 no valid", word_valid, 0);
        send_body(8'hC3); tick(^8'hC3);
        for (int i = 0; i < 12; i++) tick(i[0]);
        check("R10 fault sticky", parity_fault, 1);
        check("R10 word frozen", word_out, 8'h5A);
        check("R10 no valid", word_valid, 0);

        // recover from fault
        rst = 1'b1; tick(1'b1);
        rst = 1'b0;
        check("R11 fault cleared", parity_fault, 0);
        check("R1 word cleared", word_out, 0);
        send_body(8'h6E); tick(^8'h6E);
        check("R11 valid after reset", word_valid, 1);
        check("R11 byte 6E", word_out, 8'h6E);
        repeat (3) tick(1'b0);
        finish_run();
    end
endmodule